// File: doc/BRIEF.md
# Function Configuration Space with Base Address Decoding

This block is the configuration register space of one device function on a PCI-style bus, plus the address decoder that its base address registers control. A host reaches the 256-byte space through a simple request port. Each request carries a bus/device/function tuple and a byte offset, and may read or write a byte, a word or a dword. The block answers only when the tuple matches its own position, which arrives on strap inputs. The first 64 bytes hold the read-only identity fields, a command register with the two space enables, up to six base address registers and an interrupt line byte. Everything else reads as zero.

Each base address register describes its own region. The bits below the region size are hardwired to zero, and the low type bits are fixed. Software can therefore learn the size by writing all ones and reading the register back. Firmware then places the region by writing the upper bits. The decoder compares an incoming memory or I/O address against those upper bits only. It raises a per-register hit and a space-wide hit once the matching enable in the command register is set.

Top module: `cfg_space_bar`

## Requirements
- R1: A request is accepted only when `cfg_bus`, `cfg_dev` and `cfg_fn` equal `my_bus`, `my_dev` and `my_fn`. Any other request gets no acknowledge, changes no register and returns zero data.
- R2: The dword at offset 0x00 reads vendor ID in bits 15:0 and device ID in bits 31:16. The dword at 0x08 reads the revision in bits 7:0 and the 24-bit class code in bits 31:8, with the base class in bits 31:24. Writes to these dwords are ignored.
- R3: `cfg_size` selects the access width: 0 is a byte, 1 is a word and 2 is a dword. Data is right-justified, so the byte at the lowest offset sits in bits 7:0 (little-endian). A word access with offset bit 0 set, a dword access with offset bits 1:0 nonzero, and size 3 are all ignored on write and read as zero.
- R4: The command register at 0x04 has I/O enable in bit 0 and memory enable in bit 1, both read/write. All its other bits read zero.
- R5: Base address register i sits at offset 0x10+4*i. Bit 0 reads 1 for an I/O region and 0 for a memory region. For a memory region, bit 3 reads 1 when it is prefetchable, and bits 2:1 read 0. Bits below log2 of the region size read zero. Writing all ones reads back the writable upper bits as ones, OR'd with the type bits.
- R6: After reset, every base, both enables and the interrupt line are zero, and no hit output is asserted.
- R7: The byte at 0x3C is a read/write interrupt line with no effect on the block. Bytes 0x3D to 0x3F read zero and ignore writes.
- R8: All other offsets read zero and ignore writes. This covers base registers beyond `NUM_BAR` and everything from 0x40 to 0xFF.
- R9: `bar_hit[i]` is set when all three of these hold:
  - `dec_io` equals the region's I/O type;
  - that space's enable is set;
  - `dec_addr` bits above the size equal the programmed base.
  
  `mem_hit` and `io_hit` are the OR of the memory and I/O region hits. The addresses base−1 and base+size never hit.
- R10: `cfg_ack` is high exactly one cycle after an accepted request. `cfg_rdata` carries read data in that cycle and is zero in every other cycle, including write acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| my_bus | input | 8 | This function's bus number |
| my_dev | input | 5 | This function's device number |
| my_fn | input | 3 | This function's function number |
| cfg_req | input | 1 | Configuration request valid |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_bus | input | 8 | Target bus number |
| cfg_dev | input | 5 | Target device number |
| cfg_fn | input | 3 | Target function number |
| cfg_off | input | 8 | Byte offset in the space |
| cfg_size | input | 2 | 0 byte, 1 word, 2 dword |
| cfg_wdata | input | 32 | Right-justified write data |
| cfg_ack | output | 1 | Acknowledge, one cycle after an accepted request |
| cfg_rdata | output | 32 | Right-justified read data |
| dec_addr | input | 32 | Address to decode |
| dec_io | input | 1 | 1 = I/O space address, 0 = memory |
| mem_hit | output | 1 | Address falls in an enabled memory region |
| io_hit | output | 1 | Address falls in an enabled I/O region |
| bar_hit | output | NUM_BAR | Per-register hit |

## Verification
The decode outputs are combinational from the stored bases and enables. A base corrupted by a write that should have been masked, dropped or ignored therefore shows up on `bar_hit` in the very next cycle at the addresses just inside and just outside the region. The same error is visible on readback one cycle after the read request. A lane-steering or alignment fault shows up as wrong bytes on `cfg_rdata` in the acknowledge cycle of the access, or as a register that changed without being written. A tuple-matching fault shows up as an acknowledge on a foreign request, or as state left behind by such a request.

// File: rtl/cfg_pkg.sv
// Package: shared constants for the configuration space.
// Assumes dword-indexed register placement inside a 256-byte space.
package cfg_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } acc_size_e;

    localparam int MAX_BAR = 6;

    // dword indices (offset / 4) that software relies on
    localparam logic [5:0] DW_ID    = 6'h00;
    localparam logic [5:0] DW_CMD   = 6'h01;
    localparam logic [5:0] DW_CLASS = 6'h02;
    localparam logic [5:0] DW_BAR0  = 6'h04;
    localparam logic [5:0] DW_INTL  = 6'h0F;

    localparam int CMD_IO_BIT  = 0;
    localparam int CMD_MEM_BIT = 1;
endpackage

// File: rtl/cfg_lane.sv
// Module: cfg_lane
// Turns a byte offset and access size into byte enables, steers write data
// onto its byte lanes and right-justifies read data. Assumes little-endian
// lanes; misaligned or illegal sizes yield no enables and zero read data.
module cfg_lane
    import cfg_pkg::*;
(
    input  logic [1:0]  byte_off,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    input  logic [31:0] rword,
    output logic [3:0]  be,
    output logic [31:0] wlane,
    output logic [31:0] rjust
);
    logic        aligned;
    logic [31:0] rmask;
    logic [4:0]  shamt;

    assign shamt = {byte_off, 3'b000};

    // Purpose: decode size and alignment into lane enables and a read mask
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: begin
                aligned = 1'b1;
                rmask   = 32'h0000_00FF;
                be      = 4'b0001 << byte_off;
            end
            SZ_WORD: begin
                aligned = ~byte_off[0];
                rmask   = 32'h0000_FFFF;
                be      = 4'b0011 << byte_off;
            end
            SZ_DWORD: begin
                aligned = (byte_off == 2'b00);
                rmask   = 32'hFFFF_FFFF;
                be      = 4'b1111;
            end
            default: begin
                aligned = 1'b0;
                rmask   = 32'h0;
                be      = 4'b0000;
            end
        endcase
        if (!aligned) be = 4'b0000;
    end

    assign wlane = wdata << shamt;
    assign rjust = aligned ? ((rword >> shamt) & rmask) : 32'h0;
endmodule

// File: rtl/cfg_bar.sv
// Module: cfg_bar
// One self-sizing base address register and its comparator. Bits below
// LOG2 are hardwired to zero; the type bits are constants. Assumes
// LOG2 >= 4 for memory regions and LOG2 >= 2 for I/O regions.
module cfg_bar #(
    parameter int unsigned LOG2 = 12,
    parameter bit          IS_IO = 1'b0,
    parameter bit          PREF  = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [3:0]  be,
    input  logic [31:0] wlane,
    input  logic        space_en,
    input  logic [31:0] dec_addr,
    input  logic        dec_io,
    output logic [31:0] rval,
    output logic        hit
);
    localparam logic [31:0] WMASK = ~((32'h1 << LOG2) - 32'h1);
    localparam logic [31:0] TYPE  = IS_IO ? 32'h1 : (PREF ? 32'h8 : 32'h0);

    logic [31:0] base_q;

    // Purpose: store only the writable upper bits, byte by byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= 32'h0;
        end else if (wr) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) base_q[8*b +: 8] <= wlane[8*b +: 8] & WMASK[8*b +: 8];
            end
        end
    end

    assign rval = base_q | TYPE;
    assign hit  = space_en && (dec_io == IS_IO) && ((dec_addr & WMASK) == base_q);
endmodule

// File: rtl/cfg_space_bar.sv
// Module: cfg_space_bar (top)
// Configuration space of one function: identity, command enables, up to
// six self-sizing base registers, interrupt line; plus region decode.
// Assumes one request at a time; the response is registered one cycle later.
module cfg_space_bar
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
    parameter logic [15:0] DEVICE_ID  = 16'h0B17,
    parameter logic [7:0]  REV_ID     = 8'h02,
    parameter logic [23:0] CLASS_CODE = 24'h020000,
    parameter int          NUM_BAR    = 3,
    parameter int unsigned BAR_LOG2 [MAX_BAR] = '{12, 8, 20, 16, 16, 16},
    parameter logic [MAX_BAR-1:0] BAR_IO   = 6'b000010,
    parameter logic [MAX_BAR-1:0] BAR_PREF = 6'b000100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         my_bus,
    input  logic [4:0]         my_dev,
    input  logic [2:0]         my_fn,
    input  logic               cfg_req,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_bus,
    input  logic [4:0]         cfg_dev,
    input  logic [2:0]         cfg_fn,
    input  logic [7:0]         cfg_off,
    input  logic [1:0]         cfg_size,
    input  logic [31:0]        cfg_wdata,
    output logic               cfg_ack,
    output logic [31:0]        cfg_rdata,
    input  logic [31:0]        dec_addr,
    input  logic               dec_io,
    output logic               mem_hit,
    output logic               io_hit,
    output logic [NUM_BAR-1:0] bar_hit
);
    localparam logic [NUM_BAR-1:0] IO_SET = BAR_IO[NUM_BAR-1:0];

    logic        sel, wr_ok;
    logic [5:0]  dw;
    logic [3:0]  be;
    logic [31:0] wlane, rword, rjust;
    logic [1:0]  cmd_q;
    logic [7:0]  intl_q;
    logic [31:0] bar_rval [NUM_BAR];

    assign sel   = cfg_req && (cfg_bus == my_bus) && (cfg_dev == my_dev) && (cfg_fn == my_fn);
    assign wr_ok = sel && cfg_we;
    assign dw    = cfg_off[7:2];

    cfg_lane u_lane (
        .byte_off (cfg_off[1:0]),
        .size     (cfg_size),
        .wdata    (cfg_wdata),
        .rword    (rword),
        .be       (be),
        .wlane    (wlane),
        .rjust    (rjust)
    );

    // Purpose: command register holding the two space enables
    always_ff @(posedge clk) begin
        if (!rst_n)                                cmd_q <= 2'b00;
        else if (wr_ok && dw == DW_CMD && be[0])   cmd_q <= wlane[1:0];
    end

    // Purpose: interrupt line byte, plain storage
    always_ff @(posedge clk) begin
        if (!rst_n)                                intl_q <= 8'h00;
        else if (wr_ok && dw == DW_INTL && be[0])  intl_q <= wlane[7:0];
    end

    for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
        localparam logic [5:0] MY_DW = DW_BAR0 + 6'(i);
        cfg_bar #(
            .LOG2  (BAR_LOG2[i]),
            .IS_IO (BAR_IO[i]),
            .PREF  (BAR_PREF[i])
        ) u_bar (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_ok && dw == MY_DW),
            .be       (be),
            .wlane    (wlane),
            .space_en (BAR_IO[i] ? cmd_q[CMD_IO_BIT] : cmd_q[CMD_MEM_BIT]),
            .dec_addr (dec_addr),
            .dec_io   (dec_io),
            .rval     (bar_rval[i]),
            .hit      (bar_hit[i])
        );
    end

    // Purpose: select the addressed dword; unimplemented offsets give zero
    always_comb begin
        rword = 32'h0;
        if (dw == DW_ID)         rword = {DEVICE_ID, VENDOR_ID};
        else if (dw == DW_CMD)   rword = {30'h0, cmd_q};
        else if (dw == DW_CLASS) rword = {CLASS_CODE, REV_ID};
        else if (dw == DW_INTL)  rword = {24'h0, intl_q};
        else begin
            for (int i = 0; i < NUM_BAR; i++) begin
                if (dw == DW_BAR0 + 6'(i)) rword = bar_rval[i];
            end
        end
    end

    // Purpose: registered acknowledge and read data, zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_ack   <= 1'b0;
            cfg_rdata <= 32'h0;
        end else begin
            cfg_ack   <= sel;
            cfg_rdata <= (sel && !cfg_we) ? rjust : 32'h0;
        end
    end

    assign mem_hit = |(bar_hit & ~IO_SET);
    assign io_hit  = |(bar_hit & IO_SET);
endmodule

// File: rtl/cfg_space_bar_chk.sv
// Module: cfg_space_bar_chk
// Port-level properties of cfg_space_bar, attached by bind below.
// Assumes the same NUM_BAR as the instance it watches.
module cfg_space_bar_chk #(
    parameter int NUM_BAR = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         my_bus,
    input logic [4:0]         my_dev,
    input logic [2:0]         my_fn,
    input logic               cfg_req,
    input logic               cfg_we,
    input logic [7:0]         cfg_bus,
    input logic [4:0]         cfg_dev,
    input logic [2:0]         cfg_fn,
    input logic [7:0]         cfg_off,
    input logic [1:0]         cfg_size,
    input logic               cfg_ack,
    input logic [31:0]        cfg_rdata,
    input logic               dec_io,
    input logic               mem_hit,
    input logic               io_hit,
    input logic [NUM_BAR-1:0] bar_hit
);
    logic here, misal, seen_wr;

    assign here  = cfg_req && cfg_bus == my_bus && cfg_dev == my_dev && cfg_fn == my_fn;
    assign misal = (cfg_size == 2'd3) || (cfg_size == 2'd1 && cfg_off[0])
                 || (cfg_size == 2'd2 && cfg_off[1:0] != 2'b00);

    // Purpose: remember whether any accepted write occurred since reset
    always_ff @(posedge clk) begin
        if (!rst_n)              seen_wr <= 1'b0;
        else if (here && cfg_we) seen_wr <= 1'b1;
    end

    p_foreign_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !here) |=> !cfg_ack);
    p_ack_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        here |=> cfg_ack);
    p_idle_rdata_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ack |-> cfg_rdata == 32'h0);
    p_misaligned_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (here && !cfg_we && misal) |=> cfg_rdata == 32'h0);
    p_byte_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (here && !cfg_we && cfg_size == 2'd0) |=> cfg_rdata[31:8] == 24'h0);
    p_mem_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> !dec_io);
    p_io_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> dec_io);
    p_summary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|bar_hit) == (mem_hit || io_hit));
    p_reset_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_hit || io_hit) |-> seen_wr);
endmodule

bind cfg_space_bar cfg_space_bar_chk #(.NUM_BAR(NUM_BAR)) u_chk (
    .clk(clk), .rst_n(rst_n), .my_bus(my_bus), .my_dev(my_dev), .my_fn(my_fn),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
    .cfg_fn(cfg_fn), .cfg_off(cfg_off), .cfg_size(cfg_size), .cfg_ack(cfg_ack),
    .cfg_rdata(cfg_rdata), .dec_io(dec_io), .mem_hit(mem_hit), .io_hit(io_hit),
    .bar_hit(bar_hit)
);

// File: tb/sim_cfg_space_bar.sv
module sim_cfg_space_bar;
    localparam logic [15:0] VID = 16'hA5C3;
    localparam logic [15:0] DID = 16'h0B17;
    localparam logic [7:0]  REV = 8'h02;
    localparam logic [23:0] CLS = 24'h020000;
    localparam int NB = 3;
    localparam int unsigned LG [6] = '{12, 8, 20, 16, 16, 16};
    localparam logic [5:0] ISIO = 6'b000010;
    localparam logic [5:0] PF   = 6'b000100;
    localparam logic [7:0] MB = 8'h02;
    localparam logic [4:0] MD = 5'd13;
    localparam logic [2:0] MF = 3'd1;

    logic clk = 0, rst_n = 0;
    logic cfg_req = 0, cfg_we = 0, dec_io = 0;
    logic [7:0] cfg_bus = 0, cfg_off = 0;
    logic [4:0] cfg_dev = 0;
    logic [2:0] cfg_fn = 0;
    logic [1:0] cfg_size = 0;
    logic [31:0] cfg_wdata = 0, dec_addr = 0;
    logic cfg_ack, mem_hit, io_hit;
    logic [31:0] cfg_rdata;
    logic [NB-1:0] bar_hit;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [1:0] sh_cmd = 0;
    logic [7:0] sh_intl = 0;
    logic [31:0] sh_bar [6] = '{default: 32'h0};

    always #5 clk = ~clk;

    cfg_space_bar #(.VENDOR_ID(VID), .DEVICE_ID(DID), .REV_ID(REV), .CLASS_CODE(CLS),
        .NUM_BAR(NB), .BAR_LOG2(LG), .BAR_IO(ISIO), .BAR_PREF(PF)) u0 (
        .clk(clk), .rst_n(rst_n), .my_bus(MB), .my_dev(MD), .my_fn(MF),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
        .cfg_fn(cfg_fn), .cfg_off(cfg_off), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata), .dec_addr(dec_addr), .dec_io(dec_io),
        .mem_hit(mem_hit), .io_hit(io_hit), .bar_hit(bar_hit));

    function automatic logic [31:0] bmask(int i);
        return ~((32'h1 << LG[i]) - 32'h1);
    endfunction
    function automatic logic [31:0] btype(int i);
        return ISIO[i] ? 32'h1 : (PF[i] ? 32'h8 : 32'h0);
    endfunction
    function automatic logic [31:0] exp_dw(int idx);
        if (idx == 0) return {DID, VID};
        if (idx == 1) return {30'h0, sh_cmd};
        if (idx == 2) return {CLS, REV};
        if (idx == 15) return {24'h0, sh_intl};
        if (idx >= 4 && idx < 4 + NB) return sh_bar[idx-4] | btype(idx-4);
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit we, input logic [7:0] off, input logic [1:0] sz,
                       input logic [31:0] wd, input int foreign,
                       output logic [31:0] rd, output logic ack);
        @(negedge clk);
        cfg_req = 1; cfg_we = we; cfg_off = off; cfg_size = sz; cfg_wdata = wd;
        cfg_bus = (foreign == 1) ? MB + 8'd1 : MB;
        cfg_dev = (foreign == 2) ? MD ^ 5'd1 : MD;
        cfg_fn  = (foreign == 3) ? MF ^ 3'd4 : MF;
        @(negedge clk);
        rd = cfg_rdata; ack = cfg_ack;
        cfg_req = 0; cfg_we = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] off, input logic [1:0] sz,
                          input logic [31:0] exp);
        logic [31:0] r; logic a;
        acc(0, off, sz, 0, 0, r, a);
        chk({tag, " ack"}, {31'h0, a}, 32'h1);
        chk(tag, r, exp);
    endtask

    task automatic wr(input logic [7:0] off, input logic [1:0] sz, input logic [31:0] wd);
        logic [31:0] r; logic a;
        acc(1, off, sz, wd, 0, r, a);
        chk("R10 write ack data", r, 32'h0);
    endtask

    task automatic probe(input string tag, input logic [31:0] a, input logic io,
                         input logic [NB-1:0] exp);
        @(negedge clk);
        dec_addr = a; dec_io = io;
        #1;
        chk({tag, " bar_hit"}, 32'(bar_hit), 32'(exp));
        chk({tag, " mem_hit"}, {31'h0, mem_hit}, {31'h0, |(exp & ~ISIO[NB-1:0])});
        chk({tag, " io_hit"}, {31'h0, io_hit}, {31'h0, |(exp & ISIO[NB-1:0])});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r, e; logic a;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R6: reset state at the ports
        chk("R6 ack after reset", {31'h0, cfg_ack}, 32'h0);
        chk("R6 rdata after reset", cfg_rdata, 32'h0);
        probe("R6 no hit at zero mem", 32'h0, 0, '0);
        probe("R6 no hit at zero io", 32'h0, 1, '0);

        // R2 R4 R5 R6 R7 R8: full dword sweep of reset contents
        for (int d = 0; d < 64; d++) rd_chk("R8 R2 R5 dword sweep", 8'(d * 4), 2'd2, exp_dw(d));

        // R3: byte and word reads over the header and interrupt line
        for (int o = 0; o < 16; o++) begin
            e = (exp_dw(o / 4) >> (8 * (o % 4))) & 32'hFF;
            rd_chk("R3 byte read", 8'(o), 2'd0, e);
        end
        for (int o = 0; o < 16; o += 2) begin
            e = (exp_dw(o / 4) >> (8 * (o % 4))) & 32'hFFFF;
            rd_chk("R3 word read", 8'(o), 2'd1, e);
        end
        rd_chk("R3 misaligned word", 8'h01, 2'd1, 32'h0);
        rd_chk("R3 misaligned dword", 8'h02, 2'd2, 32'h0);
        rd_chk("R3 size 3 read", 8'h00, 2'd3, 32'h0);

        // R2 R8: writes to read-only and unimplemented offsets are ignored
        wr(8'h00, 2'd2, 32'hFFFF_FFFF);
        wr(8'h08, 2'd2, 32'hFFFF_FFFF);
        wr(8'h1C, 2'd2, 32'hFFFF_FFFF);
        wr(8'h40, 2'd2, 32'hFFFF_FFFF);
        wr(8'hFC, 2'd2, 32'hFFFF_FFFF);
        rd_chk("R2 vendor/device after write", 8'h00, 2'd2, {DID, VID});
        rd_chk("R2 class after write", 8'h08, 2'd2, {CLS, REV});
        rd_chk("R8 unused bar after write", 8'h1C, 2'd2, 32'h0);
        rd_chk("R8 0x40 after write", 8'h40, 2'd2, 32'h0);
        rd_chk("R8 0xFC after write", 8'hFC, 2'd2, 32'h0);
        rd_chk("R2 base class byte", 8'h0B, 2'd0, {24'h0, CLS[23:16]});

        // R1: foreign tuples get no response and change nothing
        for (int f = 1; f <= 3; f++) begin
            acc(1, 8'h3C, 2'd0, 32'hFF, f, r, a);
            chk("R1 foreign write ack", {31'h0, a}, 32'h0);
            acc(0, 8'h00, 2'd2, 0, f, r, a);
            chk("R1 foreign read ack", {31'h0, a}, 32'h0);
            chk("R1 foreign read data", r, 32'h0);
        end
        rd_chk("R1 intline untouched", 8'h3C, 2'd2, 32'h0);

        // R3: misaligned write is ignored
        wr(8'h3E, 2'd2, 32'h0000_00AA);
        rd_chk("R3 misaligned write ignored", 8'h3C, 2'd2, 32'h0);

        // R7: interrupt line storage, upper bytes fixed at zero
        wr(8'h3C, 2'd0, 32'h5A); sh_intl = 8'h5A;
        wr(8'h3D, 2'd0, 32'hFF);
        wr(8'h3E, 2'd1, 32'hFFFF);
        rd_chk("R7 intline dword", 8'h3C, 2'd2, 32'h0000_005A);
        rd_chk("R7 intline byte", 8'h3C, 2'd0, 32'h5A);

        // R5: sizing by writing all ones to each base register
        for (int i = 0; i < NB; i++) begin
            wr(8'(16 + 4 * i), 2'd2, 32'hFFFF_FFFF);
            sh_bar[i] = bmask(i);
            rd_chk("R5 sizing readback", 8'(16 + 4 * i), 2'd2, bmask(i) | btype(i));
        end

        // R4: command bits beyond the enables read zero
        wr(8'h04, 2'd1, 32'hFFFC); sh_cmd = 2'b00;
        rd_chk("R4 command upper bits", 8'h04, 2'd2, 32'h0);

        // R9: place regions; byte writes exercise lane steering (R3)
        wr(8'h10, 2'd2, 32'h8000_2000); sh_bar[0] = 32'h8000_2000;
        wr(8'h14, 2'd2, 32'h0);
        wr(8'h15, 2'd0, 32'hC1); sh_bar[1] = 32'h0000_C100;
        wr(8'h1A, 2'd1, 32'h8010);
        wr(8'h18, 2'd1, 32'h0);   sh_bar[2] = 32'h8010_0000;
        for (int i = 0; i < NB; i++)
            rd_chk("R5 R3 placed base", 8'(16 + 4 * i), 2'd2, sh_bar[i] | btype(i));

        // R4: enables still clear, no decode
        probe("R4 mem disabled", sh_bar[0], 0, '0);
        probe("R4 io disabled", sh_bar[1], 1, '0);

        // R4: memory only
        wr(8'h04, 2'd0, 32'h2); sh_cmd = 2'b10;
        rd_chk("R4 command mem only", 8'h04, 2'd2, 32'h2);
        probe("R4 mem enabled", sh_bar[2], 0, 3'b100);
        probe("R4 io still off", sh_bar[1], 1, '0);

        wr(8'h04, 2'd2, 32'h3); sh_cmd = 2'b11;
        // R9: inside, edges and just outside each region, both spaces
        for (int i = 0; i < NB; i++) begin
            logic [31:0] sz;
            logic [NB-1:0] me;
            sz = 32'h1 << LG[i];
            me = NB'(1) << i;
            probe("R9 base", sh_bar[i], ISIO[i], me);
            probe("R9 middle", sh_bar[i] + sz / 2, ISIO[i], me);
            probe("R9 last", sh_bar[i] + sz - 1, ISIO[i], me);
            probe("R9 below", sh_bar[i] - 1, ISIO[i], '0);
            probe("R9 above", sh_bar[i] + sz, ISIO[i], '0);
            probe("R9 wrong space", sh_bar[i], ~ISIO[i], '0);
        end

        // R6: reset clears bases and enables
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        sh_cmd = 0; sh_intl = 0;
        for (int i = 0; i < 6; i++) sh_bar[i] = 0;
        probe("R6 no hit after reset", 32'h8010_0000, 0, '0);
        rd_chk("R6 base cleared", 8'h18, 2'd2, btype(2));
        rd_chk("R6 intline cleared", 8'h3C, 2'd2, 32'h0);

        finish_run();
    end
endmodule